// File: doc/BRIEF.md
# Eight-Lane Fixed-Carrier Quadrature Upconverter

This block shifts a complex baseband stream up to one of a small set of carrier frequencies. It takes eight I/Q samples per fabric clock, so a 125 MHz clock gives a 1 GSPS aggregate rate. The carrier can only be `n·fs/M`, where `fs` is the aggregate sample rate, `M` is a power of two fixed when the block is built (16 by default, 8 as the lighter option) and `n` is an index from 0 to M−1. Because of this limit, every lane needs only a short constant table of rotation coefficients. There is no fine phase accumulator.

Fine frequency offsets are expected to be in the baseband tones that feed the lanes. The rotated pair drives the I and Q inputs of a quadrature mixer for single-sideband operation. A carrier index is loaded with a strobe, and all eight lanes switch to it together on the same cycle boundary. Data passes through a fixed three-stage pipeline, and a valid flag travels with it.

Top module: `fxduc_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, every output lane reads 0 and the carrier index is 0.
- R2: `out_valid` equals `in_valid` from three clock edges earlier. The lane data of that sample appears in the same cycle.
- R3: With carrier index 0, every output lane equals its input lane exactly, three cycles later.
- R4: For lane j (bits `[16j+15:16j]`, lane 0 is the earliest sample), the sample captured t clock edges after the most recent load uses phase index k = (n·(8t + j)) mod M. The count t advances on every clock, whether or not `in_valid` is high.
- R5: The rotation is I' = I·C − Q·S and Q' = I·S + Q·C. C is the cosine entry at position p = k·(16/M) of a 16-entry table with 1.0 = 32768: 32768, 30274, 23170, 12540, 0, then the negated entries in mirror order. S is the cosine entry at (p − 4) mod 16. Results are rounded by adding 16384 and shifting right arithmetically by 15.
- R6: A rotated value above 32767 becomes 32767, and one below −32768 becomes −32768.
- R7: `car_sel` is taken only on a clock edge where `car_load` is 1. The sample captured on that same edge still uses the old index. The next sample uses the new index with t = 0. Without the strobe, changes on `car_sel` have no effect on the outputs.
- R8: When built with M = 8, `car_sel` is 3 bits wide and the table position is 2k.
- R9: When a cycle carries no valid sample, the output lanes keep the values of the last valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input lanes carry a sample this cycle |
| in_i | input | LANES*DW | In-phase baseband lanes, lane 0 in the low bits |
| in_q | input | LANES*DW | Quadrature baseband lanes |
| car_load | input | 1 | Strobe that captures a new carrier index |
| car_sel | input | log2(M) | Carrier index n |
| out_valid | output | 1 | Output lanes carry a rotated sample |
| out_i | output | LANES*DW | Rotated in-phase lanes |
| out_q | output | LANES*DW | Rotated quadrature lanes |

## Verification
The properties assume that `in_valid` and `car_load` stay low while reset is asserted and for a few cycles after release. During that time the internal reset is still held by the synchronizer. The latency and bypass properties also take for granted that a sample's carrier index is the one registered on the edge that captures it. The bench idles for six cycles after reset and starts every scenario with a load strobe, so its own cycle count lines up with the design's without reading any internal state. An identical stimulus drives a second instance built with M = 8.

// File: rtl/fxduc_pkg.sv
package fxduc_pkg;

  localparam int COEF_W = 18;
  localparam int FRAC   = 15;

  // cosine of 2*pi*k/16, unity scaled to 2^FRAC
  function automatic logic signed [COEF_W-1:0] cos_tbl(input logic [3:0] k);
    logic signed [COEF_W-1:0] v;
    case (k)
      4'd0:  v = 18'sd32768;
      4'd1:  v = 18'sd30274;
      4'd2:  v = 18'sd23170;
      4'd3:  v = 18'sd12540;
      4'd4:  v = 18'sd0;
      4'd5:  v = -18'sd12540;
      4'd6:  v = -18'sd23170;
      4'd7:  v = -18'sd30274;
      4'd8:  v = -18'sd32768;
      4'd9:  v = -18'sd30274;
      4'd10: v = -18'sd23170;
      4'd11: v = -18'sd12540;
      4'd12: v = 18'sd0;
      4'd13: v = 18'sd12540;
      4'd14: v = 18'sd23170;
      default: v = 18'sd30274;
    endcase
    return v;
  endfunction

  // sine is the cosine a quarter turn back
  function automatic logic signed [COEF_W-1:0] sin_tbl(input logic [3:0] k);
    return cos_tbl(k - 4'd4);
  endfunction

endpackage

// File: rtl/fxduc_rstsync.sv
module fxduc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;

endmodule

// File: rtl/fxduc_phase.sv
module fxduc_phase #(
  parameter int LANES = 8,
  parameter int M     = 16,
  localparam int IW   = $clog2(M)
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  car_load,
  input  logic [IW-1:0]         car_sel,
  output logic [IW-1:0]         car_q,
  output logic [IW-1:0]         cyc_q,
  output logic [LANES*IW-1:0]   lane_idx
);

  logic [IW-1:0] car_d;
  logic [IW-1:0] cyc_d;

  // next state: a load restarts the cycle count, otherwise count every clock
  always_comb begin
    if (car_load) begin
      car_d = car_sel;
      cyc_d = '0;
    end else begin
      car_d = car_q;
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= '0;
      cyc_q <= '0;
    end else begin
      car_q <= car_d;
      cyc_q <= cyc_d;
    end
  end

  // phase of lane j: n*(LANES*t + j) modulo M (M a power of two)
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      lane_idx[j*IW +: IW] = IW'(int'(car_q) * (LANES * int'(cyc_q) + j));
    end
  end

endmodule

// File: rtl/fxduc_lane.sv
module fxduc_lane
  import fxduc_pkg::*;
#(
  parameter int DW = 16,
  parameter int M  = 16,
  localparam int IW = $clog2(M),
  localparam int SH = 4 - IW,
  localparam int PW = DW + COEF_W,
  localparam int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 en1,
  input  logic                 en2,
  input  logic                 en3,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [IW-1:0]        idx,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  // stage 1: operands and coefficients
  logic [3:0]                  k16;
  logic signed [DW-1:0]        a_i_q, a_q_q;
  logic signed [COEF_W-1:0]    c_q, s_q;
  logic signed [COEF_W-1:0]    c_d, s_d;

  // stage 2: partial products
  logic signed [PW-1:0]        p_ic_q, p_qs_q, p_is_q, p_qc_q;
  logic signed [PW-1:0]        p_ic_d, p_qs_d, p_is_d, p_qc_d;

  // stage 3: rounded and clipped results
  logic signed [SW-1:0]        sum_i, sum_q, sh_i, sh_q;
  logic signed [DW-1:0]        r_i_d, r_q_d;

  assign k16 = 4'(idx) << SH;

  always_comb begin
    c_d = cos_tbl(k16);
    s_d = sin_tbl(k16);
  end

  always_comb begin
    p_ic_d = PW'(a_i_q) * PW'(c_q);
    p_qs_d = PW'(a_q_q) * PW'(s_q);
    p_is_d = PW'(a_i_q) * PW'(s_q);
    p_qc_d = PW'(a_q_q) * PW'(c_q);
  end

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_comb begin
    sum_i = SW'(p_ic_q) - SW'(p_qs_q);
    sum_q = SW'(p_is_q) + SW'(p_qc_q);
    sh_i  = (sum_i + HALF) >>> FRAC;
    sh_q  = (sum_q + HALF) >>> FRAC;
    r_i_d = clip(sh_i);
    r_q_d = clip(sh_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_i_q <= '0;
      a_q_q <= '0;
      c_q   <= '0;
      s_q   <= '0;
    end else if (en1) begin
      a_i_q <= in_i;
      a_q_q <= in_q;
      c_q   <= c_d;
      s_q   <= s_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      p_ic_q <= '0;
      p_qs_q <= '0;
      p_is_q <= '0;
      p_qc_q <= '0;
    end else if (en2) begin
      p_ic_q <= p_ic_d;
      p_qs_q <= p_qs_d;
      p_is_q <= p_is_d;
      p_qc_q <= p_qc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_i <= '0;
      out_q <= '0;
    end else if (en3) begin
      out_i <= r_i_d;
      out_q <= r_q_d;
    end
  end

endmodule

// File: rtl/fxduc_top.sv
module fxduc_top #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int M     = 16,
  localparam int IW   = $clog2(M),
  localparam int BUS  = LANES * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BUS-1:0]   in_i,
  input  logic [BUS-1:0]   in_q,
  input  logic             car_load,
  input  logic [IW-1:0]    car_sel,
  output logic             out_valid,
  output logic [BUS-1:0]   out_i,
  output logic [BUS-1:0]   out_q
);

  logic                 rst_i_n;
  logic [IW-1:0]        car_q;
  logic [IW-1:0]        cyc_q;
  logic [LANES*IW-1:0]  lane_idx;
  logic [2:0]           vld_q;
  logic [2:0]           vld_d;

  fxduc_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fxduc_phase #(
    .LANES (LANES),
    .M     (M)
  ) u_phase (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .car_load (car_load),
    .car_sel  (car_sel),
    .car_q    (car_q),
    .cyc_q    (cyc_q),
    .lane_idx (lane_idx)
  );

  always_comb vld_d = {vld_q[1:0], in_valid};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) vld_q <= '0;
    else          vld_q <= vld_d;
  end

  assign out_valid = vld_q[2];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    fxduc_lane #(
      .DW (DW),
      .M  (M)
    ) u_lane (
      .clk    (clk),
      .rst_ni (rst_i_n),
      .en1    (in_valid),
      .en2    (vld_q[0]),
      .en3    (vld_q[1]),
      .in_i   (in_i[j*DW +: DW]),
      .in_q   (in_q[j*DW +: DW]),
      .idx    (lane_idx[j*IW +: IW]),
      .out_i  (out_i[j*DW +: DW]),
      .out_q  (out_q[j*DW +: DW])
    );
  end

endmodule

// File: rtl/fxduc_chk.sv
module fxduc_chk #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int M     = 16,
  localparam int IW   = $clog2(M),
  localparam int BUS  = LANES * DW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [BUS-1:0]  in_i,
  input logic [BUS-1:0]  in_q,
  input logic            car_load,
  input logic [IW-1:0]   car_sel,
  input logic            out_valid,
  input logic [BUS-1:0]  out_i,
  input logic [BUS-1:0]  out_q,
  input logic [IW-1:0]   car_q,
  input logic [IW-1:0]   cyc_q
);

  logic [2:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen_q <= '0;
    else if (seen_q != 3'd7)  seen_q <= seen_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q < 3'd3) |-> !out_valid);

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd7) |-> (out_valid == $past(in_valid, 3)));

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd7 && out_valid && $past(car_q, 3) == '0)
      |-> (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd7 && car_load) |=> (car_q == $past(car_sel) && cyc_q == '0));

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd7 && !car_load) |=> $stable(car_q));

  // R4
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd7 && !car_load) |=> (cyc_q == IW'($past(cyc_q) + 1'b1)));

endmodule

bind fxduc_top fxduc_chk #(
  .LANES (LANES),
  .DW    (DW),
  .M     (M)
) u_fxduc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_i      (in_i),
  .in_q      (in_q),
  .car_load  (car_load),
  .car_sel   (car_sel),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q),
  .car_q     (car_q),
  .cyc_q     (cyc_q)
);

// File: tb/test_fxduc_top.sv
module test_fxduc_top;

  localparam int CLK_T = 8;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int BUS   = LANES * DW;
  localparam int WD    = 20000;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [BUS-1:0] in_i, in_q;
  logic           car_load;
  logic [3:0]     car_sel;
  logic           out_valid, out8_valid;
  logic [BUS-1:0] out_i, out_q, out8_i, out8_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int b_n, b8_n, b_t;
  int unsigned seed = 32'h1234_5678;

  logic           h_v  [3];
  logic [BUS-1:0] h_i  [3], h_q [3], h8_i [3], h8_q [3];
  string          h_tag[3];
  logic [BUS-1:0] last_i, last_q, last8_i, last8_q;

  fxduc_top #(.LANES(LANES), .DW(DW), .M(16)) i_fxduc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .car_load(car_load), .car_sel(car_sel),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  fxduc_top #(.LANES(LANES), .DW(DW), .M(8)) i_fxduc_top_m8 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .car_load(car_load), .car_sel(car_sel[2:0]),
    .out_valid(out8_valid), .out_i(out8_i), .out_q(out8_q));

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic longint cosv(input int p);
    case (p & 15)
      0: return 32768;   1: return 30274;   2: return 23170;   3: return 12540;
      4: return 0;       5: return -12540;  6: return -23170;  7: return -30274;
      8: return -32768;  9: return -30274;  10: return -23170; 11: return -12540;
      12: return 0;      13: return 12540;  14: return 23170;  default: return 30274;
    endcase
  endfunction

  function automatic int satr(input longint v);
    longint r;
    r = (v + 16384) >>> 15;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic int next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return int'(seed & 32'hFFFF) - 32768;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
    bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // one clock: check the sample from three steps back, then drive a new one
  task automatic step(input logic v, input logic ld, input logic [3:0] sel,
                      input int mode, input string tag);
    logic [BUS-1:0] ni, nq, ei, eq, e8i, e8q;
    @(negedge clk);
    total++;
    if (out_valid !== h_v[2] || out8_valid !== h_v[2]) begin
      bad++;
      $display("FAIL R2 out_valid actual=%b/%b expected=%b", out_valid, out8_valid, h_v[2]);
    end
    if (h_v[2]) begin
      last_i = h_i[2]; last_q = h_q[2]; last8_i = h8_i[2]; last8_q = h8_q[2];
    end
    total++;
    if (out_i !== last_i) fail_line(h_v[2] ? h_tag[2] : "R9", "lane I", out_i, last_i);
    else if (out_q !== last_q) fail_line(h_v[2] ? h_tag[2] : "R9", "lane Q", out_q, last_q);
    total++;
    if (out8_i !== last8_i) fail_line("R8", "m8 lane I", out8_i, last8_i);
    else if (out8_q !== last8_q) fail_line("R8", "m8 lane Q", out8_q, last8_q);

    for (int j = 0; j < LANES; j++) begin
      int a, b, k, k8;
      case (mode)
        1:       begin a = 100;   b = -32768; end
        2:       begin a = 32767; b = 32767;  end
        3:       begin a = -32768; b = -32768; end
        default: begin a = next_rand(); b = next_rand(); end
      endcase
      ni[j*DW +: DW] = 16'(a);
      nq[j*DW +: DW] = 16'(b);
      k  = (b_n  * (8 * b_t + j)) % 16;
      k8 = (b8_n * (8 * b_t + j)) % 8;
      ei [j*DW +: DW] = 16'(satr(longint'(a) * cosv(k) - longint'(b) * cosv(k - 4)));
      eq [j*DW +: DW] = 16'(satr(longint'(a) * cosv(k - 4) + longint'(b) * cosv(k)));
      e8i[j*DW +: DW] = 16'(satr(longint'(a) * cosv(2*k8) - longint'(b) * cosv(2*k8 - 4)));
      e8q[j*DW +: DW] = 16'(satr(longint'(a) * cosv(2*k8 - 4) + longint'(b) * cosv(2*k8)));
    end
    in_valid = v; in_i = ni; in_q = nq; car_load = ld; car_sel = sel;

    h_v[2] = h_v[1]; h_i[2] = h_i[1]; h_q[2] = h_q[1];
    h8_i[2] = h8_i[1]; h8_q[2] = h8_q[1]; h_tag[2] = h_tag[1];
    h_v[1] = h_v[0]; h_i[1] = h_i[0]; h_q[1] = h_q[0];
    h8_i[1] = h8_i[0]; h8_q[1] = h8_q[0]; h_tag[1] = h_tag[0];
    h_v[0] = v; h_i[0] = ei; h_q[0] = eq; h8_i[0] = e8i; h8_q[0] = e8q; h_tag[0] = tag;

    if (ld) begin
      b_n = int'(sel); b8_n = int'(sel[2:0]); b_t = 0;
    end else begin
      b_t = (b_t + 1) % 16;
    end
  endtask

  task automatic flush(input string tag);
    for (int s = 0; s < 4; s++) step(1'b0, 1'b0, 4'd0, 0, tag);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0 || out8_valid !== 1'b0)
      fail_line("R1", "reset outputs", out_i, '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0)
      fail_line("R1", "after release", out_i, '0);
  endtask

  task automatic t_bypass();
    step(1'b0, 1'b1, 4'd0, 0, "R3");
    for (int s = 0; s < 6; s++) step(1'b1, 1'b0, 4'd0, 0, "R3");
    step(1'b1, 1'b0, 4'd0, 2, "R3");
    step(1'b1, 1'b0, 4'd0, 3, "R3");
    flush("R3");
  endtask

  task automatic t_rotate();
    step(1'b0, 1'b1, 4'd1, 0, "R5");
    for (int s = 0; s < 10; s++) step(1'b1, 1'b0, 4'd1, 0, "R5");
    for (int n = 3; n < 16; n += 4) begin
      step(1'b1, 1'b1, 4'(n), 0, "R4");
      for (int s = 0; s < 9; s++) step(1'b1, 1'b0, 4'(n), 0, "R4");
    end
    flush("R4");
  endtask

  task automatic t_sat();
    step(1'b0, 1'b1, 4'd4, 0, "R6");
    for (int s = 0; s < 3; s++) step(1'b1, 1'b0, 4'd4, 1, "R6");
    step(1'b0, 1'b1, 4'd2, 0, "R6");
    for (int s = 0; s < 3; s++) step(1'b1, 1'b0, 4'd2, 2, "R6");
    for (int s = 0; s < 3; s++) step(1'b1, 1'b0, 4'd2, 3, "R6");
    flush("R6");
  endtask

  task automatic t_load();
    step(1'b1, 1'b1, 4'd5, 0, "R7");
    // selector wiggles without the strobe: no effect
    for (int s = 0; s < 6; s++) step(1'b1, 1'b0, 4'(s + 9), 0, "R7");
    // back-to-back switch while samples flow
    step(1'b1, 1'b1, 4'd11, 0, "R7");
    step(1'b1, 1'b1, 4'd6, 0, "R7");
    for (int s = 0; s < 5; s++) step(1'b1, 1'b0, 4'd0, 0, "R7");
    flush("R7");
  endtask

  task automatic t_gaps();
    step(1'b1, 1'b1, 4'd7, 0, "R9");
    for (int s = 0; s < 16; s++) step(((s % 3) == 0) ? 1'b1 : 1'b0, 1'b0, 4'd0, 0, "R9");
    flush("R9");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; car_load = 1'b0; car_sel = '0;
    b_n = 0; b8_n = 0; b_t = 0;
    last_i = '0; last_q = '0; last8_i = '0; last8_q = '0;
    for (int s = 0; s < 3; s++) begin
      h_v[s] = 1'b0; h_i[s] = '0; h_q[s] = '0; h8_i[s] = '0; h8_q[s] = '0; h_tag[s] = "R2";
    end
    t_reset();
    t_bypass();
    t_rotate();
    t_sat();
    t_load();
    t_gaps();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule